// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block puts a two-wire serial bus back into a known state after a target has been left mid-transfer and holds the data line low. A single-cycle request starts the sequence. The block first lets both open-drain lines float high. It then drives a train of nine clock pulses. After each high phase it samples the data line and keeps a note if the line was ever high. Every target that was stuck partway through a byte gets enough clocks to finish it and let go of the data line.

If the data line was seen high at least once, the block checks whether both lines now rest high. It then makes a START followed by a STOP, and it keeps the clock line released the whole time. Some targets lock up again if the clock drops between the two conditions, and this rule prevents that. A bus-free wait follows before the result is reported. If the data line never rose, the block skips the START/STOP and reports a wedged bus. Each clock high phase allows for a target that stretches the clock, up to a fixed limit, and the sequence continues once that limit runs out.

The block drives the two pull-down enables directly. A pad or an open-drain cell turns them into bus levels. Normal byte transfers belong to another block.

Top module: `twrRecover`

## Requirements
- R1: After reset, and whenever the block is idle, both pull-down enables are 0 (lines released), `busy` is 0, and `done`, `fail` and `notIdle` are 0 until the first result.
- R2: A request issues exactly NUM_CLOCKS (default 9) clock pulses. In each pulse `sclPullEn` is 1 for at least LOW_US and then 0. The data line is sampled HIGH_US after the clock line is seen high.
- R3: All NUM_CLOCKS pulses are issued even after the data line has been seen high. A single high sample anywhere in the train (the first through the last) counts as a pass.
- R4: If no sample saw the data line high, `done` pulses with `fail`=1, and `sdaPullEn` never rises during that run (no START/STOP).
- R5: On a pass, `sdaPullEn` rises once (START) and falls once (STOP). Both edges happen while the clock line is high, and `sclPullEn` stays 0 from the START to the end of the run.
- R6: The clock line is high for at least SETUP_US before the START, and `sdaPullEn` stays 1 for at least HOLD_US.
- R7: At least BUF_US passes between the STOP and the `done` pulse.
- R8: After a pass, `notIdle`=1 if either line was low at the idle check after the train. The START/STOP is still issued.
- R9: In each high phase the block waits for the clock line to read high, for at most STRETCH_US. A target that holds the clock low for good does not stop the sequence, and all pulses and the result still follow.
- R10: A request while `busy` is 1 is ignored: the running sequence is not restarted and gives exactly one `done`.
- R11: `done` is a one-cycle pulse given when `busy` falls. `fail` equals "no high sample seen". `fail` and `notIdle` hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqStart | input | 1 | One-cycle request to run the recovery |
| sclIn | input | 1 | Clock line level read back from the pad |
| sdaIn | input | 1 | Data line level read back from the pad |
| sclPullEn | output | 1 | 1 pulls the clock line low, 0 releases it |
| sdaPullEn | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Wedged bus: data line never seen high |
| notIdle | output | 1 | Warning: lines not both high before START |

## Verification
The assertions assume that `reqStart` is a clean synchronous pulse. They also assume the line inputs are the wired-AND of this block's enables and a target model. A target may hold either line low but can never drive it high against a pull.

The stimulus keeps to this. Each line level is computed as the released enable ANDed with the target's own hold. The bench sweeps the pulse at which a stuck target releases the data line over every position in the train and one position past it. It also adds a stretching target, a target that holds the clock low permanently, and a second request during a run.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [2:0] {
    TMR_LOW,
    TMR_STRETCH,
    TMR_DWELL,
    TMR_SETUP,
    TMR_HOLD,
    TMR_BUSFREE
  } tmrSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_RISE,
    ST_DWELL,
    ST_DECIDE,
    ST_SETUP,
    ST_HOLD,
    ST_BUSFREE
  } twrState_e;

  typedef struct packed {
    logic    clearRun;
    logic    load;
    tmrSel_e loadSel;
    logic    sample;
    logic    checkIdle;
    logic    finish;
    logic    sclPullNext;
    logic    sdaPullNext;
  } twrStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/twr_datapath.sv
module twr_datapath
  import twr_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int LOW_US      = 2,
  parameter int HIGH_US     = 1,
  parameter int STRETCH_US  = 1000,
  parameter int SETUP_US    = 1,
  parameter int HOLD_US     = 1,
  parameter int BUS_FREE_US = 60,
  parameter int NUM_CLOCKS  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  twrStrobe_t strobe,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclSync,
  output logic       timerZero,
  output logic       lastPulse,
  output logic       sawHigh,
  output logic       sclPullEn,
  output logic       sdaPullEn,
  output logic       done,
  output logic       fail,
  output logic       notIdle
);

  localparam int LowCyc     = LOW_US * CLK_PER_US;
  localparam int StretchCyc = STRETCH_US * CLK_PER_US;
  localparam int DwellCyc   = HIGH_US * CLK_PER_US;
  localparam int SetupCyc   = SETUP_US * CLK_PER_US;
  localparam int HoldCyc    = HOLD_US * CLK_PER_US;
  localparam int BusFreeCyc = BUS_FREE_US * CLK_PER_US;
  localparam int MaxCyc     = maxOf(maxOf(maxOf(LowCyc, StretchCyc), maxOf(DwellCyc, SetupCyc)),
                                    maxOf(HoldCyc, BusFreeCyc));
  localparam int TmrW       = $clog2(MaxCyc + 1);
  localparam int CntW       = $clog2(NUM_CLOCKS + 1);

  // Line synchronizers, one chain per line
  logic [SYNC_STAGES-1:0] sclChain;
  logic [SYNC_STAGES-1:0] sdaChain;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  logic sdaSync;
  assign sclSync = sclChain[SYNC_STAGES-1];
  assign sdaSync = sdaChain[SYNC_STAGES-1];

  // Shared phase timer
  logic [TmrW-1:0] timer;
  logic [TmrW-1:0] loadVal;

  always_comb begin
    unique case (strobe.loadSel)
      TMR_LOW:     loadVal = TmrW'(LowCyc);
      TMR_STRETCH: loadVal = TmrW'(StretchCyc);
      TMR_DWELL:   loadVal = TmrW'(DwellCyc);
      TMR_SETUP:   loadVal = TmrW'(SetupCyc);
      TMR_HOLD:    loadVal = TmrW'(HoldCyc);
      TMR_BUSFREE: loadVal = TmrW'(BusFreeCyc);
      default:     loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.load) begin
      timer <= loadVal;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign timerZero = (timer == '0);

  // Pulse counter and sticky high flag
  logic [CntW-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      sawHigh  <= 1'b0;
    end else if (strobe.clearRun) begin
      pulseCnt <= '0;
      sawHigh  <= 1'b0;
    end else if (strobe.sample) begin
      pulseCnt <= pulseCnt + 1'b1;
      sawHigh  <= sawHigh | sdaSync;
    end
  end

  assign lastPulse = (pulseCnt == CntW'(NUM_CLOCKS - 1));

  // Result and pad enable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail      <= 1'b0;
      notIdle   <= 1'b0;
      done      <= 1'b0;
      sclPullEn <= 1'b0;
      sdaPullEn <= 1'b0;
    end else begin
      if (strobe.clearRun) begin
        fail    <= 1'b0;
        notIdle <= 1'b0;
      end else begin
        if (strobe.checkIdle) notIdle <= ~(sclSync & sdaSync);
        if (strobe.finish)    fail    <= ~sawHigh;
      end
      done      <= strobe.finish;
      sclPullEn <= strobe.sclPullNext;
      sdaPullEn <= strobe.sdaPullNext;
    end
  end

endmodule

// File: rtl/twr_control.sv
module twr_control
  import twr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       sclSync,
  input  logic       timerZero,
  input  logic       lastPulse,
  input  logic       sawHigh,
  output twrStrobe_t strobe,
  output logic       busy
);

  twrState_e state;
  twrState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState        = state;
    strobe           = '0;
    strobe.loadSel   = TMR_LOW;
    unique case (state)
      ST_IDLE: begin
        if (reqStart) begin
          strobe.clearRun = 1'b1;
          strobe.load     = 1'b1;
          strobe.loadSel  = TMR_LOW;
          nextState       = ST_LOW;
        end
      end
      ST_LOW: begin
        if (timerZero) begin
          strobe.load    = 1'b1;
          strobe.loadSel = TMR_STRETCH;
          nextState      = ST_RISE;
        end
      end
      ST_RISE: begin
        // proceed on a seen rise or once the stretch limit runs out
        if (sclSync || timerZero) begin
          strobe.load    = 1'b1;
          strobe.loadSel = TMR_DWELL;
          nextState      = ST_DWELL;
        end
      end
      ST_DWELL: begin
        if (timerZero) begin
          strobe.sample = 1'b1;
          if (lastPulse) begin
            nextState = ST_DECIDE;
          end else begin
            strobe.load    = 1'b1;
            strobe.loadSel = TMR_LOW;
            nextState      = ST_LOW;
          end
        end
      end
      ST_DECIDE: begin
        if (sawHigh) begin
          strobe.checkIdle = 1'b1;
          strobe.load      = 1'b1;
          strobe.loadSel   = TMR_SETUP;
          nextState        = ST_SETUP;
        end else begin
          strobe.finish = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_SETUP: begin
        if (timerZero) begin
          strobe.load    = 1'b1;
          strobe.loadSel = TMR_HOLD;
          nextState      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (timerZero) begin
          strobe.load    = 1'b1;
          strobe.loadSel = TMR_BUSFREE;
          nextState      = ST_BUSFREE;
        end
      end
      ST_BUSFREE: begin
        if (timerZero) begin
          strobe.finish = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.sclPullNext = (nextState == ST_LOW);
    strobe.sdaPullNext = (nextState == ST_HOLD);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/twrRecover.sv
module twrRecover
  import twr_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int LOW_US      = 2,
  parameter int HIGH_US     = 1,
  parameter int STRETCH_US  = 1000,
  parameter int SETUP_US    = 1,
  parameter int HOLD_US     = 1,
  parameter int BUS_FREE_US = 60,
  parameter int NUM_CLOCKS  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqStart,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclPullEn,
  output logic sdaPullEn,
  output logic busy,
  output logic done,
  output logic fail,
  output logic notIdle
);

  twrStrobe_t strobe;
  logic sclSync;
  logic timerZero;
  logic lastPulse;
  logic sawHigh;

  twr_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqStart  (reqStart),
    .sclSync   (sclSync),
    .timerZero (timerZero),
    .lastPulse (lastPulse),
    .sawHigh   (sawHigh),
    .strobe    (strobe),
    .busy      (busy)
  );

  twr_datapath #(
    .CLK_PER_US  (CLK_PER_US),
    .LOW_US      (LOW_US),
    .HIGH_US     (HIGH_US),
    .STRETCH_US  (STRETCH_US),
    .SETUP_US    (SETUP_US),
    .HOLD_US     (HOLD_US),
    .BUS_FREE_US (BUS_FREE_US),
    .NUM_CLOCKS  (NUM_CLOCKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sclSync   (sclSync),
    .timerZero (timerZero),
    .lastPulse (lastPulse),
    .sawHigh   (sawHigh),
    .sclPullEn (sclPullEn),
    .sdaPullEn (sdaPullEn),
    .done      (done),
    .fail      (fail),
    .notIdle   (notIdle)
  );

endmodule

// File: rtl/twrRecover_chk.sv
module twrRecover_chk #(
  parameter int NUM_CLOCKS = 9
) (
  input logic clk,
  input logic rstN,
  input logic reqStart,
  input logic sclPullEn,
  input logic sdaPullEn,
  input logic busy,
  input logic done,
  input logic fail
);

  localparam int CntW = $clog2(NUM_CLOCKS + 2);

  logic            prevScl;
  logic [CntW-1:0] pullCnt;
  logic            startPulled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl     <= 1'b0;
      pullCnt     <= '0;
      startPulled <= 1'b0;
    end else begin
      prevScl <= sclPullEn;
      if (!busy && reqStart) begin
        pullCnt     <= '0;
        startPulled <= 1'b0;
      end else begin
        if (sclPullEn && !prevScl) pullCnt <= pullCnt + 1'b1;
        if (sdaPullEn) startPulled <= 1'b1;
      end
    end
  end

  // R1: idle means both lines released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclPullEn && !sdaPullEn));

  // R2 and R10: one run gives exactly the configured pulse count
  p_pulse_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pullCnt == CntW'(NUM_CLOCKS)));

  // R4: a failed run never pulled the data line
  p_fail_no_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> !startPulled);

  // R5: clock never pulled while data is pulled
  p_scl_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullEn |-> !sclPullEn);

  // R11: done is a single cycle and coincides with the end of busy
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_at_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind twrRecover twrRecover_chk #(.NUM_CLOCKS(NUM_CLOCKS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqStart  (reqStart),
  .sclPullEn (sclPullEn),
  .sdaPullEn (sdaPullEn),
  .busy      (busy),
  .done      (done),
  .fail      (fail)
);

// File: tb/twrRecover_tb.sv
module twrRecover_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int CPU         = 2;
  localparam int LOW_US      = 2;
  localparam int HIGH_US     = 1;
  localparam int STRETCH_US  = 10;
  localparam int SETUP_US    = 1;
  localparam int HOLD_US     = 2;
  localparam int BUS_FREE_US = 6;
  localparam int NCLK        = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0;
  logic sclPullEn, sdaPullEn, busy, done, fail, notIdle;

  // target model
  int  relK = 0;
  int  stretchAmt = 0;
  bit  stuckScl = 0;
  int  stretchCnt = 0;
  int  lineRises = 0;

  logic sclLine, sdaLine;
  assign sclLine = !sclPullEn && !stuckScl && (stretchCnt == 0);
  assign sdaLine = !sdaPullEn && !(relK > lineRises);

  twrRecover #(
    .CLK_PER_US(CPU), .LOW_US(LOW_US), .HIGH_US(HIGH_US), .STRETCH_US(STRETCH_US),
    .SETUP_US(SETUP_US), .HOLD_US(HOLD_US), .BUS_FREE_US(BUS_FREE_US),
    .NUM_CLOCKS(NCLK), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullEn(sclPullEn), .sdaPullEn(sdaPullEn), .busy(busy), .done(done),
    .fail(fail), .notIdle(notIdle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // monitor state
  bit clrMon = 0;
  int pullRises, doneCnt, sinceSclHigh, setupMeas, holdCnt, busFreeCnt;
  bit startSeen, stopSeen, startSclHigh, stopSclHigh, badDrop, afterStop;
  bit capFail, capNotIdle;
  logic pScl, pSdaPull, pSclPull;

  always @(negedge clk) begin
    cycles++;
    if (clrMon) begin
      lineRises = 0; pullRises = 0; doneCnt = 0; sinceSclHigh = 0; setupMeas = 0;
      holdCnt = 0; busFreeCnt = 0; startSeen = 0; stopSeen = 0; startSclHigh = 0;
      stopSclHigh = 0; badDrop = 0; afterStop = 0; capFail = 0; capNotIdle = 0;
    end else begin
      if (sclLine && !pScl) begin lineRises++; sinceSclHigh = 0; end
      if (sclLine) sinceSclHigh++;
      if (sclPullEn && !pSclPull) pullRises++;
      if (sdaPullEn && !pSdaPull) begin
        startSeen = 1; startSclHigh = sclLine; setupMeas = sinceSclHigh - 1;
      end
      if (sdaPullEn) holdCnt++;
      if (!sdaPullEn && pSdaPull) begin
        stopSeen = 1; stopSclHigh = sclLine; afterStop = 1;
      end
      if (startSeen && sclPullEn) badDrop = 1;
      if (afterStop && !done) busFreeCnt++;
      if (done) begin doneCnt++; capFail = fail; capNotIdle = notIdle; afterStop = 0; end
    end
    pScl = sclLine; pSdaPull = sdaPullEn; pSclPull = sclPullEn;
    if (sclPullEn) stretchCnt = stretchAmt;
    else if (stretchCnt > 0) stretchCnt--;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOnce(input int k, input int stretch, input bit stuck, input bit extraReq);
    bit expFail, expNotIdle;
    int waitCnt;
    @(negedge clk);
    relK = k; stretchAmt = stretch; stuckScl = stuck; clrMon = 1;
    @(negedge clk);
    clrMon = 0;
    reqStart = 1;
    @(negedge clk);
    reqStart = 0;
    waitCnt = 0;
    while (doneCnt == 0 && waitCnt < 5000) begin
      if (extraReq && waitCnt == 30) reqStart = 1;
      else reqStart = 0;
      @(negedge clk);
      waitCnt++;
    end
    reqStart = 0;
    repeat (40) @(negedge clk);
    expFail = (k > NCLK);
    expNotIdle = stuck;
    check(doneCnt == 1, "R10/R11 done count", doneCnt, 1);
    check(pullRises == NCLK, "R2 pulse count", pullRises, NCLK);
    check(capFail == expFail, "R3/R4 fail", capFail, expFail);
    check(fail == expFail, "R11 fail held", fail, expFail);
    check(capNotIdle == expNotIdle, "R8 notIdle", capNotIdle, expNotIdle);
    check(notIdle == expNotIdle, "R11 notIdle held", notIdle, expNotIdle);
    if (!stuck) check(lineRises == NCLK, "R9 line rises", lineRises, NCLK);
    if (expFail) begin
      check(!startSeen, "R4 no START", startSeen, 0);
    end else begin
      check(startSeen && stopSeen, "R5 START/STOP", startSeen + stopSeen, 2);
      check(!badDrop, "R5 clock kept released", badDrop, 0);
      check(holdCnt >= HOLD_US*CPU, "R6 hold", holdCnt, HOLD_US*CPU);
      check(busFreeCnt >= BUS_FREE_US*CPU, "R7 bus free", busFreeCnt, BUS_FREE_US*CPU);
      if (!stuck) begin
        check(startSclHigh && stopSclHigh, "R5 edges with clock high",
              startSclHigh + stopSclHigh, 2);
        check(setupMeas >= SETUP_US*CPU, "R6 setup", setupMeas, SETUP_US*CPU);
      end
    end
    check(!busy && !sclPullEn && !sdaPullEn, "R1 idle released",
          {busy, sclPullEn, sdaPullEn}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!sclPullEn && !sdaPullEn && !busy && !done && !fail && !notIdle,
          "R1 reset state", {sclPullEn, sdaPullEn, busy, done, fail, notIdle}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    // R3 sweep: release position 0 (never stuck) through one past the train
    for (int k = 0; k <= NCLK + 1; k++) runOnce(k, 0, 0, 0);
    // R9 clock stretching target
    runOnce(3, 5, 0, 0);
    // R9/R8 clock held low permanently
    runOnce(0, 0, 1, 0);
    // R10 request during a run
    runOnce(0, 0, 0, 1);
    runOnce(NCLK + 5, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule